// File: doc/BRIEF.md
# Serial Bit-Rate Prescaler

This block turns the system clock into the bit-rate timing for a two-wire bus master. Four counting stages run one after another. The first stage counts twice the programmed half-period plus one. The second divides by a power of two. The third divides by a programmable linear factor. The last is a fixed decade stage. The block emits a one-cycle pulse once per serial clock period. It also emits a quarter-phase pulse with a two-bit slot index, which the bus engine uses to place data-line changes and samples.

Host software writes the settings through a narrow write port. Each write goes into a shadow copy. The counters use the shadow copy only at the end of a period, or while the prescaler is stopped. A plain run enable starts and stops the prescaler, and a running flag shows whether the counters are active. There is no data stream in or out of this block, so every pin is plain control or status and no valid/ready handshake applies.

Top module: `serclk_prescaler`

## Requirements
- R1: While running, the interval between successive `scl_tick` pulses is 2·(H+1)·2^N·(M+1)·10 system clock cycles. H is the active half-period, N the active power-of-two exponent and M the active linear factor.
- R2: `scl_tick` is high for exactly one cycle per period.
- R3: Each period has exactly four `qtr_tick` pulses. With U = 2·(H+1)·2^N·(M+1), they come 3U, 5U, 8U and 10U cycles after the period starts, and carry `qtr_idx` 0, 1, 2 and 3. The pulse with index 3 is in the same cycle as `scl_tick`.
- R4: A half-period write (`cfg_sel`=0) stores `cfg_wdata[7:0]`, except that a value below 5 is stored as 5.
- R5: A clock-control write (`cfg_sel`=1) takes M from `cfg_wdata[6:3]` and N from `cfg_wdata[2:0]`. Bit 7 is ignored.
- R6: After reset all outputs are low, and the settings are H=0x18, M=2, N=0, which gives a 1500-cycle period.
- R7: A write made during a period does not change that period. It applies from the next period on.
- R8: When `run_en` is high while the prescaler is stopped, `running` rises at the next edge and counting starts from zero.
- R9: When `run_en` is low, the current period still runs to its end. `running` falls at the same edge that raises the final `scl_tick`.
- R10: While `running` is low, neither tick is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Run request |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_sel | input | 1 | 0: half-period, 1: clock control |
| cfg_wdata | input | 8 | Write data |
| scl_tick | output | 1 | One pulse per serial clock period |
| qtr_tick | output | 1 | Quarter-phase pulse |
| qtr_idx | output | 2 | Slot of the current quarter pulse |
| running | output | 1 | Counters active |

## Verification
The bench runs four settings: the reset default, a clamped half-period with unit linear and exponent factors, and two mixed settings. Each one weights a different stage, so an error in any single stage's terminal count changes the measured period. A write made in the middle of a period shows whether settings are shadowed (R7). The old period length must appear once before the new one. A stop request made mid-period separates an early stop from a correct stop at the end of the period. A restart after the stop checks the start latency.

// File: rtl/prs_pkg.sv
package prs_pkg;
  localparam int HP_W   = 8;
  localparam int M_W    = 4;
  localparam int N_W    = 3;
  localparam int DEC    = 10;
  localparam int PHASES = 4;

  // slot lookup: a decade count c ends quarter j when c+1 == ceil(j*DEC/PHASES)
  function automatic logic [2:0] qtr_slot(input logic [3:0] c);
    logic [2:0] r;
    r = 3'b000;
    for (int j = 1; j <= PHASES; j++) begin
      if (int'(c) + 1 == (j * DEC + PHASES - 1) / PHASES)
        r = {1'b1, 2'(j - 1)};
    end
    return r;
  endfunction
endpackage

// File: rtl/prs_cfg_shadow.sv
module prs_cfg_shadow #(
  parameter int HP_W   = 8,
  parameter int M_W    = 4,
  parameter int N_W    = 3,
  parameter int HP_MIN = 5,
  parameter int HP_RST = 24,
  parameter int M_RST  = 2,
  parameter int N_RST  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            commit,
  output logic [HP_W-1:0] hp_act,
  output logic [M_W-1:0]  m_act,
  output logic [N_W-1:0]  n_act
);
  localparam logic [HP_W-1:0] HP_FLOOR = HP_W'(HP_MIN);

  logic [HP_W-1:0] hp_pend;
  logic [M_W-1:0]  m_pend;
  logic [N_W-1:0]  n_pend;
  logic [HP_W-1:0] hp_in;

  assign hp_in = (cfg_wdata[HP_W-1:0] < HP_FLOOR) ? HP_FLOOR : cfg_wdata[HP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp_pend <= HP_W'(HP_RST);
      m_pend  <= M_W'(M_RST);
      n_pend  <= N_W'(N_RST);
    end else if (cfg_wr) begin
      if (!cfg_sel) hp_pend <= hp_in;
      else begin
        m_pend <= cfg_wdata[N_W+M_W-1:N_W];
        n_pend <= cfg_wdata[N_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hp_act <= HP_W'(HP_RST);
      m_act  <= M_W'(M_RST);
      n_act  <= N_W'(N_RST);
    end else if (commit) begin
      hp_act <= hp_pend;
      m_act  <= m_pend;
      n_act  <= n_pend;
    end
  end
endmodule

// File: rtl/prs_div_chain.sv
module prs_div_chain #(
  parameter int HP_W = 8,
  parameter int M_W  = 4,
  parameter int N_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            running,
  input  logic [HP_W-1:0] hp_act,
  input  logic [M_W-1:0]  m_act,
  input  logic [N_W-1:0]  n_act,
  output logic            unit_tick
);
  localparam int A_W = HP_W + 1;
  localparam int B_W = (1 << N_W) - 1;

  logic [A_W-1:0] cnt_a;
  logic [B_W-1:0] cnt_b;
  logic [M_W-1:0] cnt_c;
  logic [B_W-1:0] pow_mask;
  logic           tick_a, tick_b;

  for (genvar i = 0; i < B_W; i++) begin : g_mask
    assign pow_mask[i] = (i < int'(n_act));
  end

  assign tick_a    = running && (cnt_a == {hp_act, 1'b1});
  assign tick_b    = tick_a && ((cnt_b & pow_mask) == pow_mask);
  assign unit_tick = tick_b && (cnt_c == m_act);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) begin
      cnt_a <= '0;
      cnt_b <= '0;
      cnt_c <= '0;
    end else begin
      cnt_a <= tick_a ? '0 : cnt_a + 1'b1;
      if (tick_a) cnt_b <= tick_b ? '0 : cnt_b + 1'b1;
      if (tick_b) cnt_c <= unit_tick ? '0 : cnt_c + 1'b1;
    end
  end
endmodule

// File: rtl/prs_decade_phase.sv
module prs_decade_phase
  import prs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       running,
  input  logic       unit_tick,
  output logic       period_end,
  output logic       scl_tick,
  output logic       qtr_tick,
  output logic [1:0] qtr_idx
);
  localparam logic [3:0] LAST = 4'(DEC - 1);

  logic [3:0] cnt_d;
  logic [2:0] slot;

  assign slot       = qtr_slot(cnt_d);
  assign period_end = unit_tick && (cnt_d == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) cnt_d <= '0;
    else if (unit_tick)     cnt_d <= (cnt_d == LAST) ? '0 : cnt_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_tick <= 1'b0;
      qtr_tick <= 1'b0;
      qtr_idx  <= 2'd0;
    end else begin
      scl_tick <= period_end;
      qtr_tick <= unit_tick && slot[2];
      if (unit_tick && slot[2]) qtr_idx <= slot[1:0];
    end
  end
endmodule

// File: rtl/serclk_prescaler.sv
module serclk_prescaler
  import prs_pkg::*;
#(
  parameter int HP_MIN = 5,
  parameter int HP_RST = 24,
  parameter int M_RST  = 2,
  parameter int N_RST  = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       cfg_wr,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  output logic       scl_tick,
  output logic       qtr_tick,
  output logic [1:0] qtr_idx,
  output logic       running
);
  logic [HP_W-1:0] hp_act;
  logic [M_W-1:0]  m_act;
  logic [N_W-1:0]  n_act;
  logic            unit_tick, period_end, commit;

  assign commit = !running || period_end;

  always_ff @(posedge clk) begin
    if (!rst_n)                         running <= 1'b0;
    else if (!running && run_en)        running <= 1'b1;
    else if (period_end && !run_en)     running <= 1'b0;
  end

  prs_cfg_shadow #(
    .HP_W(HP_W), .M_W(M_W), .N_W(N_W), .HP_MIN(HP_MIN),
    .HP_RST(HP_RST), .M_RST(M_RST), .N_RST(N_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .commit(commit),
    .hp_act(hp_act), .m_act(m_act), .n_act(n_act)
  );

  prs_div_chain #(.HP_W(HP_W), .M_W(M_W), .N_W(N_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .running(running),
    .hp_act(hp_act), .m_act(m_act), .n_act(n_act), .unit_tick(unit_tick)
  );

  prs_decade_phase u_dec (
    .clk(clk), .rst_n(rst_n), .running(running), .unit_tick(unit_tick),
    .period_end(period_end), .scl_tick(scl_tick),
    .qtr_tick(qtr_tick), .qtr_idx(qtr_idx)
  );
endmodule

// File: rtl/prs_checker.sv
module prs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run_en,
  input logic       scl_tick,
  input logic       qtr_tick,
  input logic [1:0] qtr_idx,
  input logic       running
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |=> !scl_tick);
  p_last_quarter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scl_tick |-> (qtr_tick && qtr_idx == 2'd3));
  p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && run_en) |=> running);
  p_stop_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> scl_tick);
  p_keep_running_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && run_en) |=> running);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !scl_tick) |=> !qtr_tick);
endmodule

bind serclk_prescaler prs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .scl_tick(scl_tick),
  .qtr_tick(qtr_tick), .qtr_idx(qtr_idx), .running(running)
);

// File: tb/sim_serclk_prescaler.sv
module sim_serclk_prescaler;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, run_en = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic scl_tick, qtr_tick, running;
  logic [1:0] qtr_idx;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serclk_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .scl_tick(scl_tick), .qtr_tick(qtr_tick),
    .qtr_idx(qtr_idx), .running(running)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  int p_hp = 24, p_m = 2, p_n = 0, a_hp = 24, a_m = 2, a_n = 0, pos = 0;
  bit m_run = 0, e_scl = 0, e_q = 0;
  int e_idx = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      p_hp = 24; p_m = 2; p_n = 0; a_hp = 24; a_m = 2; a_n = 0;
      m_run = 0; pos = 0; e_scl = 0; e_q = 0; e_idx = 0;
    end else begin
      if (!m_run) begin
        a_hp = p_hp; a_m = p_m; a_n = p_n; pos = 0; e_scl = 0; e_q = 0;
        if (run_en) m_run = 1;
      end else begin
        int unit, per, k;
        unit = 2 * (a_hp + 1) * (1 << a_n) * (a_m + 1);
        per  = unit * 10;
        e_scl = (pos == per - 1);
        e_q = 0;
        if ((pos + 1) % unit == 0) begin
          k = (pos + 1) / unit;
          case (k)
            3: begin e_q = 1; e_idx = 0; end
            5: begin e_q = 1; e_idx = 1; end
            8: begin e_q = 1; e_idx = 2; end
            10: begin e_q = 1; e_idx = 3; end
            default: ;
          endcase
        end
        if (pos == per - 1) begin
          pos = 0; a_hp = p_hp; a_m = p_m; a_n = p_n;
          if (!run_en) m_run = 0;
        end else pos++;
      end
      if (cfg_wr) begin
        if (!cfg_sel) p_hp = (cfg_wdata < 5) ? 5 : int'(cfg_wdata);
        else begin p_m = int'(cfg_wdata[6:3]); p_n = int'(cfg_wdata[2:0]); end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(scl_tick == e_scl, "R2 scl_tick vs model", scl_tick, e_scl);
      check(qtr_tick == e_q, "R3 qtr_tick vs model", qtr_tick, e_q);
      if (e_q) check(int'(qtr_idx) == e_idx, "R3 qtr_idx vs model", qtr_idx, e_idx);
      check(running == m_run, "R8 running vs model", running, m_run);
      if (!m_run) check(!scl_tick || e_scl, "R10 idle tick", scl_tick, 0);
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic wait_scl(output int c);
    do @(negedge clk); while (!scl_tick);
    c = cyc;
  endtask

  task automatic period_qtrs(output int p, output int q);
    int c0;
    wait_scl(c0);
    q = 0;
    do begin @(negedge clk); if (qtr_tick) q++; end while (!scl_tick);
    p = cyc - c0;
  endtask

  initial begin
    int t0, t1, t2, p, q;
    repeat (3) @(negedge clk);
    check(!scl_tick && !qtr_tick && !running, "R6 reset outputs", {scl_tick, qtr_tick, running}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!running, "R10 stays idle without run_en", running, 0);
    run_en = 1'b1;
    @(negedge clk);
    check(running, "R8 start one edge after run_en", running, 1);
    wait_scl(t0);
    check(t0 > 0, "R6 first tick", t0, 1);
    period_qtrs(p, q);
    check(p == 1500, "R6 R1 default period", p, 1500);
    check(q == 4, "R3 quarter count", q, 4);
    // mid-period rewrite: clamped half period, M=0 N=0, bit 7 set to be ignored
    wait_scl(t0);
    repeat (40) @(negedge clk);
    wr(1'b0, 8'd3);
    wr(1'b1, 8'h80);
    wait_scl(t1);
    check(t1 - t0 == 1500, "R7 current period unchanged", t1 - t0, 1500);
    wait_scl(t2);
    check(t2 - t1 == 120, "R4 R5 clamped half period", t2 - t1, 120);
    // H=5 M=2 N=1
    wr(1'b1, 8'h11);
    wait_scl(t0);
    period_qtrs(p, q);
    check(p == 720, "R1 R5 setting H5 M2 N1", p, 720);
    check(q == 4, "R3 quarter count", q, 4);
    // H=7 M=1 N=2
    wr(1'b0, 8'd7);
    wr(1'b1, 8'h0A);
    wait_scl(t0);
    period_qtrs(p, q);
    check(p == 1280, "R1 setting H7 M1 N2", p, 1280);
    // stop mid-period
    repeat (100) @(negedge clk);
    run_en = 1'b0;
    @(negedge clk);
    check(running, "R9 still running after stop request", running, 1);
    wait_scl(t0);
    check(!running, "R9 running falls with final tick", running, 0);
    q = 0;
    repeat (300) begin @(negedge clk); if (scl_tick || qtr_tick) q++; end
    check(q == 0, "R10 no ticks while stopped", q, 0);
    // restart
    run_en = 1'b1;
    @(negedge clk);
    check(running, "R8 restart", running, 1);
    wait_scl(t1);
    check(t1 - t0 - 301 == 1280, "R8 counts from zero after restart", t1 - t0 - 301, 1280);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule